// File: doc/BRIEF.md
# Serial Peripheral Slave Port with Write-Collision Detection

This block is the target side of a four-wire synchronous serial link. An external controller drives the serial clock, the outbound data line and an active-low chip select. The block returns one byte per frame on its own data line, most significant bit first, and at the same time collects the byte arriving from the controller. All bus pins are brought into the system clock domain through flop synchronisers, and every action is taken on edges detected there. The system clock must therefore run at least four times faster than the serial clock.

Two control inputs select one of four clocking modes. The first sets the idle level of the serial clock. The second sets whether data is captured on the first (leading) edge of each bit or on the second (trailing) edge. In the early-capture phase, every byte needs its own chip-select assertion, and a data write made while selected is refused and flagged. In the late-capture phase, chip select may stay low across several bytes, and a write between bytes loads the next one.

On the register side the block accepts a transmit word, returns the last received word, and raises two sticky flags: one for a completed byte and one for a refused write. Software clears both flags by reading status and then accessing the data register.

Top module: `spi_target_port`

## Requirements
- R1: After synchronous reset, both flags read 0, the received-data output reads 0x00, and the data-line output enable is 0.
- R2: `miso_oe` is 1 exactly while the synchronised chip select is low, and 0 otherwise.
- R3: With `ctl_idle_high`=0, the leading edge of a bit is a rising serial-clock edge. With `ctl_idle_high`=1, the leading edge is a falling edge. Transfers give the same data in both cases.
- R4: With `ctl_late_phase`=0, the first transmit bit is on `miso_out` as soon as the block is selected. Input is captured on each leading edge, and the next output bit is presented after each trailing edge.
- R5: With `ctl_late_phase`=1, each leading edge presents an output bit and each trailing edge captures an input bit. Chip select may stay low for several consecutive bytes.
- R6: A byte is 8 serial-clock cycles long, sent and received most significant bit first. Once the eighth bit is captured, the received byte appears on `rd_data` and holds until the next completed byte.
- R7: `xfer_done` becomes 1 when the eighth bit of a byte is captured, while chip select is still low.
- R8: With `ctl_late_phase`=0, a write while selected sets `wr_coll` and leaves the byte being sent unchanged.
- R9: With `ctl_late_phase`=1, a write while selected but between bytes loads the next transmit byte without a collision. A write in the middle of a byte sets `wr_coll`.
- R10: Releasing chip select in the middle of a byte abandons that byte: no completion flag is raised, `rd_data` keeps its value, and the next frame starts at bit 0.
- R11: Both flags clear when `stat_rd` is pulsed while a flag is set and is followed by a data access (`rd_en` or `wr_en`). A data access that no status read has armed leaves the flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_idle_high | input | 1 | Serial clock idle level (1 = idle high) |
| ctl_late_phase | input | 1 | 0 = capture on leading edge, 1 = capture on trailing edge |
| wr_en | input | 1 | Transmit data write strobe |
| wr_data | input | 8 | Transmit data |
| rd_en | input | 1 | Received data read strobe |
| stat_rd | input | 1 | Status read strobe, arms flag clearing |
| rd_data | output | 8 | Last completed received byte |
| xfer_done | output | 1 | Byte complete flag |
| wr_coll | output | 1 | Refused write flag |
| sck_in | input | 1 | Serial clock from controller |
| mosi_in | input | 1 | Serial data from controller |
| cs_n_in | input | 1 | Active-low chip select |
| miso_out | output | 1 | Serial data to controller |
| miso_oe | output | 1 | Output enable for `miso_out` (0 = high impedance) |

## Verification
The bench builds the block with its defaults: an 8-bit word and a two-stage synchroniser. With these values, a serial half-period of six system clocks leaves room for the synchroniser latency before every capture, in all four clocking modes. The behavioural model copies the two-stage input delay, so every output can be compared cycle by cycle, including the exact cycle the output enable rises after chip select falls. Runs of several bytes with chip select held low, mid-byte writes and an abandoned partial frame show that the bit counter restarts and the flags behave correctly at each boundary.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    // Synchronised bus pin bundle
    typedef struct packed {
        logic sck;
        logic mosi;
        logic cs_n;
    } pin_set_t;

    localparam pin_set_t PINS_IDLE = '{sck: 1'b0, mosi: 1'b0, cs_n: 1'b1};

    typedef enum logic {
        PHASE_EARLY = 1'b0,
        PHASE_LATE  = 1'b1
    } phase_t;

    // Per-cycle bus event derived from two successive pin snapshots
    typedef struct packed {
        logic sel;
        logic samp;
        logic drv;
        logic din;
    } bus_evt_t;

    function automatic bus_evt_t decode_evt(
        input logic     idle_high,
        input phase_t   phase,
        input pin_set_t prv,
        input pin_set_t cur
    );
        logic rise, fall, lead, trail;
        bus_evt_t e;
        rise   = !prv.sck && cur.sck;
        fall   = prv.sck && !cur.sck;
        lead   = idle_high ? fall : rise;
        trail  = idle_high ? rise : fall;
        e.sel  = !cur.cs_n;
        e.samp = e.sel && ((phase == PHASE_LATE) ? trail : lead);
        e.drv  = e.sel && ((phase == PHASE_LATE) ? lead : trail);
        e.din  = cur.mosi;
        return e;
    endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync
    import spi_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  pin_set_t pins_in,
    output pin_set_t pins_out
);

    pin_set_t chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= PINS_IDLE;
        end else begin
            chain[0] <= pins_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign pins_out = chain[STAGES-1];

endmodule

// File: rtl/spi_tgt_edge.sv
module spi_tgt_edge
    import spi_tgt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     idle_high,
    input  phase_t   phase,
    input  pin_set_t pins,
    output bus_evt_t evt
);

    pin_set_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= PINS_IDLE;
        else     prev_q <= pins;
    end

    always_comb evt = decode_evt(idle_high, phase, prev_q, pins);

endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift
    import spi_tgt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_t            phase,
    input  bus_evt_t          evt,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              miso,
    output logic              collide,
    output logic              done_pulse,
    output logic [DATA_W-1:0] rx_word
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] tx_q, rx_q, rx_next;
    logic [CNT_W-1:0]  bit_cnt;
    logic              busy_q;
    logic              last_bit, first_lead;

    always_comb begin
        last_bit   = (bit_cnt == LAST_BIT);
        first_lead = evt.drv && (phase == PHASE_LATE) && (bit_cnt == '0);
        collide    = wr_en && evt.sel && ((phase == PHASE_EARLY) || busy_q);
        rx_next    = {rx_q[DATA_W-2:0], evt.din};
        done_pulse = evt.samp && last_bit;
        rx_word    = rx_next;
        miso       = tx_q[DATA_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q    <= '0;
            rx_q    <= '0;
            bit_cnt <= '0;
            busy_q  <= 1'b0;
        end else if (!evt.sel) begin
            bit_cnt <= '0;
            busy_q  <= 1'b0;
            if (wr_en) tx_q <= wr_data;
        end else begin
            if (evt.samp) begin
                rx_q <= rx_next;
                if (last_bit) begin
                    bit_cnt <= '0;
                    busy_q  <= 1'b0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (evt.drv) begin
                if (first_lead) busy_q <= 1'b1;
                else            tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
            end
            if (wr_en && !collide) tx_q <= wr_data;
        end
    end

    // R10
    cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !evt.sel |=> (bit_cnt == '0));

    // R8
    wcol_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (collide && !evt.drv) |=> $stable(tx_q));

endmodule

// File: rtl/spi_tgt_flags.sv
module spi_tgt_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done_in,
    input  logic              coll_in,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              stat_rd,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              xfer_done,
    output logic              wr_coll
);

    logic armed_q;
    logic access, clr;

    always_comb begin
        access = rd_en || wr_en;
        clr    = armed_q && access;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= '0;
            xfer_done <= 1'b0;
            wr_coll   <= 1'b0;
            armed_q   <= 1'b0;
        end else begin
            if (done_in) rd_data <= rx_word;

            if (done_in)  xfer_done <= 1'b1;
            else if (clr) xfer_done <= 1'b0;

            if (coll_in)  wr_coll <= 1'b1;
            else if (clr) wr_coll <= 1'b0;

            if (access)                              armed_q <= 1'b0;
            else if (stat_rd && (xfer_done || wr_coll)) armed_q <= 1'b1;
        end
    end

    // R7
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_done) |-> $past(done_in));

    // R11
    done_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(xfer_done) |-> $past(armed_q && access));

    // R6
    buf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_in |=> $stable(rd_data));

endmodule

// File: rtl/spi_target_port.sv
module spi_target_port
    import spi_tgt_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_idle_high,
    input  logic              ctl_late_phase,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              stat_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              xfer_done,
    output logic              wr_coll,
    input  logic              sck_in,
    input  logic              mosi_in,
    input  logic              cs_n_in,
    output logic              miso_out,
    output logic              miso_oe
);

    pin_set_t          raw_pins, sync_pins;
    bus_evt_t          evt;
    phase_t            phase;
    logic              collide, done_pulse;
    logic [DATA_W-1:0] rx_word;

    assign raw_pins = '{sck: sck_in, mosi: mosi_in, cs_n: cs_n_in};
    assign phase    = phase_t'(ctl_late_phase);

    spi_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pins_in  (raw_pins),
        .pins_out (sync_pins)
    );

    spi_tgt_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .idle_high (ctl_idle_high),
        .phase     (phase),
        .pins      (sync_pins),
        .evt       (evt)
    );

    spi_tgt_shift #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .evt        (evt),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .miso       (miso_out),
        .collide    (collide),
        .done_pulse (done_pulse),
        .rx_word    (rx_word)
    );

    spi_tgt_flags #(.DATA_W(DATA_W)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .done_in   (done_pulse),
        .coll_in   (collide),
        .rx_word   (rx_word),
        .stat_rd   (stat_rd),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .rd_data   (rd_data),
        .xfer_done (xfer_done),
        .wr_coll   (wr_coll)
    );

    assign miso_oe = evt.sel;

    // R2
    oe_sync_chk: assert property (@(posedge clk) disable iff (rst)
        miso_oe |-> !sync_pins.cs_n);

endmodule

// File: tb/tb_spi_target_port.sv
module tb_spi_target_port;

    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpol = 1'b0, cpha = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, stat_rd = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic [7:0] rd_data;
    logic       xfer_done, wr_coll, miso_out, miso_oe;

    int nchecks = 0;
    int nerr    = 0;
    bit started = 1'b0;

    always #2.5 clk = ~clk;

    spi_target_port dut (
        .clk(clk), .rst(rst), .ctl_idle_high(cpol), .ctl_late_phase(cpha),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .stat_rd(stat_rd),
        .rd_data(rd_data), .xfer_done(xfer_done), .wr_coll(wr_coll),
        .sck_in(sck), .mosi_in(mosi), .cs_n_in(cs_n),
        .miso_out(miso_out), .miso_oe(miso_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model: pin history queue plus integer state
    logic [2:0] hq[$] = '{3'b001, 3'b001, 3'b001};
    logic [7:0] m_tx = 0, m_rx = 0, m_buf = 0;
    int         m_cnt = 0;
    bit         m_busy = 0, m_done = 0, m_wcol = 0, m_arm = 0;

    always @(posedge clk) begin
        if (rst) begin
            hq = '{3'b001, 3'b001, 3'b001};
            m_tx = 0; m_rx = 0; m_buf = 0; m_cnt = 0;
            m_busy = 0; m_done = 0; m_wcol = 0; m_arm = 0;
        end else begin
            logic [2:0] cur, prv;
            bit sel, rise, fall, lead, trail, samp, drv, acc, coll, clr, fin;
            cur   = hq[1];
            prv   = hq[2];
            sel   = !cur[0];
            rise  = !prv[2] && cur[2];
            fall  = prv[2] && !cur[2];
            lead  = cpol ? fall : rise;
            trail = cpol ? rise : fall;
            samp  = sel && (cpha ? trail : lead);
            drv   = sel && (cpha ? lead : trail);
            acc   = rd_en || wr_en;
            coll  = wr_en && sel && (!cpha || m_busy);
            clr   = m_arm && acc;
            fin   = 0;
            if (acc) m_arm = 0;
            else if (stat_rd && (m_done || m_wcol)) m_arm = 1;
            if (!sel) begin
                m_cnt = 0; m_busy = 0;
                if (wr_en) m_tx = wr_data;
            end else begin
                if (samp) begin
                    m_rx = {m_rx[6:0], cur[1]};
                    if (m_cnt == 7) begin m_cnt = 0; m_busy = 0; fin = 1; m_buf = m_rx; end
                    else m_cnt++;
                end
                if (drv) begin
                    if (cpha && m_cnt == 0) m_busy = 1;
                    else m_tx = m_tx << 1;
                end
                if (wr_en && !coll) m_tx = wr_data;
            end
            if (fin) m_done = 1; else if (clr) m_done = 0;
            if (coll) m_wcol = 1; else if (clr) m_wcol = 0;
            hq.push_front({sck, mosi, cs_n});
            void'(hq.pop_back());
        end
    end

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (started && !rst) begin
            chk("R2 miso_oe", miso_oe, !hq[1][0]);
            if (miso_oe) chk(cpha ? "R5 miso" : "R4 miso", miso_out, m_tx[7]);
            chk("R7 xfer_done", xfer_done, m_done);
            chk("R8 wr_coll", wr_coll, m_wcol);
            chk("R6 rd_data", rd_data, m_buf);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_data = d; wr_en = 1'b1; tick(1); wr_en = 1'b0;
    endtask

    task automatic do_read();
        rd_en = 1'b1; tick(1); rd_en = 1'b0;
    endtask

    task automatic do_stat();
        stat_rd = 1'b1; tick(1); stat_rd = 1'b0;
    endtask

    task automatic set_mode(input logic p, input logic h);
        cpol = p; cpha = h; sck = p; tick(6);
    endtask

    task automatic shift_byte(input logic [7:0] mo, output logic [7:0] mi);
        for (int i = 7; i >= 0; i--) begin
            if (!cpha) begin
                mosi = mo[i]; tick(H);
                mi[i] = miso_out; sck = ~cpol; tick(H);
                sck = cpol;
            end else begin
                sck = ~cpol; mosi = mo[i]; tick(H);
                mi[i] = miso_out; sck = cpol; tick(H);
            end
        end
        tick(H);
    endtask

    initial begin
        logic [7:0] mi;
        tick(4);
        rst = 1'b0;
        started = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 xfer_done", xfer_done, 0);
        chk("R1 wr_coll", wr_coll, 0);
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 miso_oe", miso_oe, 0);

        // Idle-low, early phase
        set_mode(0, 0);
        do_write(8'hA5);
        cs_n = 1'b0; tick(H);
        chk("R4 first bit valid on select", miso_out, 1'b1);
        shift_byte(8'h3C, mi);
        chk("R4 byte returned", mi, 8'hA5);
        chk("R7 done while selected", xfer_done, 1);
        chk("R6 received byte", rd_data, 8'h3C);
        cs_n = 1'b1; tick(6);
        chk("R2 released", miso_oe, 0);

        // R11 unarmed access leaves flag, armed access clears
        do_read();
        chk("R11 unarmed read keeps flag", xfer_done, 1);
        do_stat(); do_read();
        chk("R11 flag cleared", xfer_done, 0);

        // Idle-high, early phase, then collision
        set_mode(1, 0);
        do_write(8'h96);
        cs_n = 1'b0; tick(H);
        shift_byte(8'h5A, mi);
        chk("R3 idle-high byte returned", mi, 8'h96);
        chk("R3 idle-high received", rd_data, 8'h5A);
        cs_n = 1'b1; tick(6);
        do_stat(); do_read();
        do_write(8'h11);
        cs_n = 1'b0; tick(H);
        do_write(8'hEE);
        chk("R8 collision flagged", wr_coll, 1);
        tick(H);
        shift_byte(8'h0F, mi);
        chk("R8 shift data unchanged", mi, 8'h11);
        cs_n = 1'b1; tick(6);
        do_stat(); do_read();
        chk("R11 both flags cleared", {xfer_done, wr_coll}, 2'b00);

        // Idle-low, late phase, two bytes under one select
        set_mode(0, 1);
        do_write(8'hC3);
        cs_n = 1'b0; tick(H);
        shift_byte(8'h81, mi);
        chk("R5 first byte returned", mi, 8'hC3);
        chk("R5 first byte received", rd_data, 8'h81);
        do_write(8'h7E);
        chk("R9 between-byte write accepted", wr_coll, 0);
        shift_byte(8'h42, mi);
        chk("R9 loaded byte returned", mi, 8'h7E);
        chk("R5 second byte received", rd_data, 8'h42);
        do_stat(); do_read();
        // Partial byte, mid-byte write, abandon
        for (int i = 0; i < 3; i++) begin
            sck = ~cpol; mosi = 1'b1; tick(H);
            sck = cpol; tick(H);
        end
        do_write(8'h99);
        chk("R9 mid-byte write collides", wr_coll, 1);
        cs_n = 1'b1; tick(8);
        chk("R10 no completion", xfer_done, 0);
        chk("R10 read data kept", rd_data, 8'h42);
        do_stat(); do_read();

        // Idle-high, late phase, fresh frame starts at bit 0
        set_mode(1, 1);
        do_write(8'h24);
        cs_n = 1'b0; tick(H);
        shift_byte(8'hDB, mi);
        chk("R10 restarted frame returned", mi, 8'h24);
        chk("R3 late idle-high received", rd_data, 8'hDB);
        chk("R7 done", xfer_done, 1);
        cs_n = 1'b1; tick(6);

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchecks++;
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

endmodule